// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible side of a simple serial port. A processor reaches it through a word-addressed 32-bit bus with single-cycle read and write strobes. Read data comes out of a register one cycle after the read strobe. The block holds control words, two status words, a test word with empty flags, and several 16-bit registers that only store and return what software writes, for baud and timing setup. Bit 0 of control word 2 acts as a soft reset when it is written as zero.

Toward the line side, the block takes received bytes one at a time into a single-character holding buffer. A line break input loads a fixed break code into the same buffer. A write to the transmit data location is turned into a one-cycle byte strobe for a serializer. A single level interrupt combines the receive-ready and transmit-ready flags, each masked by control word 1, with a transmit-empty term that depends on an enable bit in the same word.

Reading the receive data location consumes the held character. A read strobe therefore has side effects, while a write only stores its value or clears flags.

Top module: `uart_regfile`

## Requirements
- R1: After reset the following values read back. Status 1 (word 0x25) = 0x3040, which is transmit-ready bit 13, RTS-state bit 12 and idle bit 6. Status 2 (0x26) = 0x4028, which is bits 14, 5 and 3. Test (0x2D) = 0x0060, which is transmit-empty bit 6 and receive-empty bit 5. Control 1 (0x20) = 0. Control 2 (0x21) = 0x0001. Control 3 (0x22) = 0x0700. FIFO control (0x24) = 0. Modulator (0x2A) = 0. Baud count (0x2B) = 4. One-millisecond (0x2C) = 0. Receive data (0x00) = 0x4000, the error flag at bit 14.
- R2: Writes to control 1, 2 and 3, FIFO control, the modulator and the one-millisecond register keep only bits 15:0 of the bus word. The register is addressed as the byte address shifted right by two.
- R3: A write to word 0x29 loads the baud count, which reads at 0x2B. Word 0x29 reads as zero. Writes to 0x2B are ignored.
- R4: Control 4 (0x23) reads zero. Writes to control 4 and to the test word are ignored. Undecoded words, the transmit word 0x10 included, read zero.
- R5: A write to control 2 with bit 0 = 0 restores the R1 values of control 1, control 3, the modulator, the baud count, both status words and the receive buffer. FIFO control and the one-millisecond register are left unchanged. Control 2 then holds the written bits 15:0 with bit 0 forced to 1.
- R6: Writing 1 clears a bit only where the bit is in the fixed clear mask: 0xCDB0 for status 1 and 0xBDD6 for status 2. Ready, idle, RTS-state, empty, complete and carrier bits are never changed by status writes.
- R7: While receive-ready (status 1 bit 9) is clear, a byte on rx_valid is stored. Storing it sets status 1 bit 9 and status 2 bit 0, and clears test bit 5.
- R8: A byte offered while receive-ready is set is discarded, and the held character is unchanged.
- R9: rx_break stores the break code 0x0800 with the same flag updates as a byte. It does so even while receive-ready is set, and it wins over a byte in the same cycle.
- R10: A read of word 0x00 returns the held word. If test bit 5 is clear, the returned word also has bit 15 set, and the read clears receive-ready and data-ready and sets receive-empty. A byte offered in the same cycle as such a read is discarded. A break in that cycle is stored.
- R11: A write to word 0x10 while control 2 bit 2 is set raises tx_strobe for the next cycle, with tx_byte = bus bits 7:0. In that cycle status 1 bit 13 reads 0, and it reads 1 afterwards. With control 2 bit 2 clear, no strobe is produced.
- R12: irq = (status1[9] & ctrl1[9]) | (ctrl1[6] & ((status1[13] & ctrl1[13]) | test[6])).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; side effects occur only with it |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | BYTE_W | Received byte |
| rx_break | input | 1 | A line break was detected this cycle |
| tx_strobe | output | 1 | One-cycle pulse carrying a byte to transmit |
| tx_byte | output | BYTE_W | Byte to transmit, valid with tx_strobe |
| irq | output | 1 | Level interrupt |

## Verification
The risky overlap is a receive-data read that consumes the held character in the same cycle as a new byte or a break arrives on the line side. The bench drives the read strobe and rx_valid, or rx_break, on the same clock edge. It expects the read to return the old character with bit 15 set. It expects a byte offered in that edge to be lost, so a follow-up read returns the old character without bit 15. It expects a break offered in that edge to be kept, so the flags stay full and the next read returns 0x8800.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  localparam int REG_W = 16;

  // word indices (byte address >> 2)
  localparam int IDX_RXD  = 'h00;
  localparam int IDX_TXD  = 'h10;
  localparam int IDX_C1   = 'h20;
  localparam int IDX_C2   = 'h21;
  localparam int IDX_C3   = 'h22;
  localparam int IDX_C4   = 'h23;
  localparam int IDX_FIFO = 'h24;
  localparam int IDX_S1   = 'h25;
  localparam int IDX_S2   = 'h26;
  localparam int IDX_BINC = 'h29;
  localparam int IDX_BMOD = 'h2A;
  localparam int IDX_BCNT = 'h2B;
  localparam int IDX_MSEC = 'h2C;
  localparam int IDX_TEST = 'h2D;

  // bit positions
  localparam int S1_RXDS  = 6;
  localparam int S1_RRDY  = 9;
  localparam int S1_RTSS  = 12;
  localparam int S1_TRDY  = 13;
  localparam int S2_RDR   = 0;
  localparam int S2_TXDC  = 3;
  localparam int S2_DCDIN = 5;
  localparam int S2_TXFE  = 14;
  localparam int TS_RXE   = 5;
  localparam int TS_TXE   = 6;
  localparam int C1_TXEIE = 6;
  localparam int C2_SRST  = 0;
  localparam int C2_TXEN  = 2;
  localparam int RX_CHRDY = 15;

  localparam logic [REG_W-1:0] S1_STICKY_RST = REG_W'((1 << S1_RXDS) | (1 << S1_RTSS));
  localparam logic [REG_W-1:0] S2_STICKY_RST =
    REG_W'((1 << S2_TXFE) | (1 << S2_TXDC) | (1 << S2_DCDIN));
  localparam logic [REG_W-1:0] S1_CLR_MASK = 16'hCDB0;
  localparam logic [REG_W-1:0] S2_CLR_MASK = 16'hBDD6;
  localparam logic [REG_W-1:0] C2_RST      = REG_W'(1 << C2_SRST);
  localparam logic [REG_W-1:0] RXD_RST     = 16'h4000;
  localparam logic [REG_W-1:0] RXD_BREAK   = 16'h0800;

  // table of plain store-and-return registers
  localparam int PASS_N = 5;

  function automatic int pass_wr_idx(int i);
    case (i)
      0: return IDX_C3;
      1: return IDX_FIFO;
      2: return IDX_BMOD;
      3: return IDX_BINC;
      default: return IDX_MSEC;
    endcase
  endfunction

  function automatic int pass_rd_idx(int i);
    case (i)
      0: return IDX_C3;
      1: return IDX_FIFO;
      2: return IDX_BMOD;
      3: return IDX_BCNT;
      default: return IDX_MSEC;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pass_rst(int i);
    case (i)
      0: return 16'h0700;
      3: return 16'h0004;
      default: return '0;
    endcase
  endfunction

  function automatic bit pass_soft(int i);
    return (i == 0) || (i == 2) || (i == 3);
  endfunction

  // write-one-to-clear restricted to a mask
  function automatic logic [REG_W-1:0] w1c(input logic [REG_W-1:0] old_v,
                                           input logic [REG_W-1:0] wv,
                                           input logic [REG_W-1:0] mask);
    return old_v & ~(wv & mask);
  endfunction

  // value returned by a receive data read
  function automatic logic [REG_W-1:0] rx_word(input logic [REG_W-1:0] held,
                                               input logic full);
    return full ? (held | REG_W'(1 << RX_CHRDY)) : held;
  endfunction

  function automatic logic irq_level(input logic trdy_s, input logic trdy_e,
                                     input logic rrdy_s, input logic rrdy_e,
                                     input logic txe_ie, input logic tx_empty);
    return (rrdy_s & rrdy_e) | (txe_ie & ((trdy_s & trdy_e) | tx_empty));
  endfunction

endpackage

// File: rtl/uart_pass_reg.sv
module uart_pass_reg
  import uart_reg_pkg::*;
#(
  parameter int WIDX_W = 10,
  parameter int WR_IDX = 0,
  parameter int RD_IDX = 0,
  parameter logic [REG_W-1:0] RST_VAL = '0,
  parameter bit SOFT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] widx,
  input  logic [REG_W-1:0]  wdata,
  output logic              rd_hit,
  output logic [REG_W-1:0]  value
);

  logic wr_hit;
  assign wr_hit = wr_en && (widx == WIDX_W'(WR_IDX));
  assign rd_hit = (widx == WIDX_W'(RD_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                value <= RST_VAL;
    else if (SOFT && soft_rst) value <= RST_VAL;
    else if (wr_hit)           value <= wdata;
  end

  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !soft_rst |=> value == $past(wdata));

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_reg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  input  logic              consume,
  output logic [REG_W-1:0]  held,
  output logic              full
);

  logic take_byte, take_break, load;
  logic [REG_W-1:0] load_val;

  assign take_break = rx_break;
  assign take_byte  = rx_valid && !full && !rx_break;
  assign load       = take_break || take_byte;
  assign load_val   = take_break ? RXD_BREAK : REG_W'(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= RXD_RST;
      full <= 1'b0;
    end else if (soft_rst) begin
      held <= RXD_RST;
      full <= 1'b0;
    end else if (load) begin
      held <= load_val;
      full <= 1'b1;
    end else if (consume) begin
      full <= 1'b0;
    end
  end

  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_break && full && !soft_rst |=> $stable(held));

  a_r9_break_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break && !soft_rst |=> full && held == RXD_BREAK);

  a_r10_consume: assert property (@(posedge clk) disable iff (!rst_n)
    consume && full && !rx_break && !soft_rst |=> !full);

  a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_break && !full && !soft_rst |=> full && held == REG_W'($past(rx_byte)));

endmodule

// File: rtl/uart_tx_port.sv
module uart_tx_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              trdy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= issue;
      if (issue) tx_byte <= wbyte;
    end
  end

  // transmit-ready is low exactly while a byte is being handed out
  assign trdy = !tx_strobe;

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> tx_strobe && tx_byte == $past(wbyte));

  a_r11_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe && !issue |=> trdy);

endmodule

// File: rtl/uart_irq_comb.sv
module uart_irq_comb
  import uart_reg_pkg::*;
(
  input  logic trdy_s,
  input  logic trdy_e,
  input  logic rrdy_s,
  input  logic rrdy_e,
  input  logic txe_ie,
  input  logic tx_empty,
  output logic irq
);

  assign irq = irq_level(trdy_s, trdy_e, rrdy_s, rrdy_e, txe_ie, tx_empty);

  always_comb begin
    a_r12_rx_term: assert (!(rrdy_s && rrdy_e) || irq);
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_break,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [REG_W-1:0]  wv;
  logic              unused_bits;

  assign widx = bus_addr[ADDR_W-1:2];
  assign wv   = bus_wdata[REG_W-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:REG_W]};

  function automatic logic at(input logic [WIDX_W-1:0] w, input int idx);
    return w == WIDX_W'(idx);
  endfunction

  // named bus events
  logic we_c1, we_c2, we_s1, we_s2, we_tx, soft_rst, rd_rx, tx_issue;
  assign we_c1    = bus_wr && at(widx, IDX_C1);
  assign we_c2    = bus_wr && at(widx, IDX_C2);
  assign we_s1    = bus_wr && at(widx, IDX_S1);
  assign we_s2    = bus_wr && at(widx, IDX_S2);
  assign we_tx    = bus_wr && at(widx, IDX_TXD);
  assign soft_rst = we_c2 && !wv[C2_SRST];
  assign rd_rx    = bus_rd && at(widx, IDX_RXD);

  // control and status storage
  logic [REG_W-1:0] ctrl1_q, ctrl2_q, s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= C2_RST;
      s1_q    <= S1_STICKY_RST;
      s2_q    <= S2_STICKY_RST;
    end else begin
      if (soft_rst) begin
        ctrl1_q <= '0;
        s1_q    <= S1_STICKY_RST;
        s2_q    <= S2_STICKY_RST;
      end else begin
        if (we_c1) ctrl1_q <= wv;
        if (we_s1) s1_q <= w1c(s1_q, wv, S1_CLR_MASK);
        if (we_s2) s2_q <= w1c(s2_q, wv, S2_CLR_MASK);
      end
      if (we_c2) ctrl2_q <= wv | C2_RST;
    end
  end

  assign tx_issue = we_tx && ctrl2_q[C2_TXEN];

  // receive holding buffer
  logic [REG_W-1:0] rx_held;
  logic             rx_full;

  uart_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_break (rx_break),
    .consume  (rd_rx),
    .held     (rx_held),
    .full     (rx_full)
  );

  // transmit strobe
  logic trdy;

  uart_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (tx_issue),
    .wbyte     (bus_wdata[BYTE_W-1:0]),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .trdy      (trdy)
  );

  // composed status views
  logic [REG_W-1:0] s1_view, s2_view, ts_view;
  always_comb begin
    s1_view = s1_q;
    s1_view[S1_RRDY] = rx_full;
    s1_view[S1_TRDY] = trdy;
    s2_view = s2_q;
    s2_view[S2_RDR] = rx_full;
    ts_view = '0;
    ts_view[TS_RXE] = !rx_full;
    ts_view[TS_TXE] = 1'b1;
  end

  // pass-through registers
  logic [REG_W-1:0] pass_val [PASS_N];
  logic [PASS_N-1:0] pass_hit;

  for (genvar g = 0; g < PASS_N; g++) begin : g_pass
    uart_pass_reg #(
      .WIDX_W  (WIDX_W),
      .WR_IDX  (pass_wr_idx(g)),
      .RD_IDX  (pass_rd_idx(g)),
      .RST_VAL (pass_rst(g)),
      .SOFT    (pass_soft(g))
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (bus_wr),
      .widx     (widx),
      .wdata    (wv),
      .rd_hit   (pass_hit[g]),
      .value    (pass_val[g])
    );
  end

  // read multiplexer
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (at(widx, IDX_RXD))  rd_mux = rx_word(rx_held, rx_full);
    if (at(widx, IDX_C1))   rd_mux = ctrl1_q;
    if (at(widx, IDX_C2))   rd_mux = ctrl2_q;
    if (at(widx, IDX_S1))   rd_mux = s1_view;
    if (at(widx, IDX_S2))   rd_mux = s2_view;
    if (at(widx, IDX_TEST)) rd_mux = ts_view;
    for (int i = 0; i < PASS_N; i++) begin
      if (pass_hit[i]) rd_mux = rd_mux | pass_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= BUS_W'(rd_mux);
  end

  // interrupt
  uart_irq_comb u_irq (
    .trdy_s   (s1_view[S1_TRDY]),
    .trdy_e   (ctrl1_q[S1_TRDY]),
    .rrdy_s   (s1_view[S1_RRDY]),
    .rrdy_e   (ctrl1_q[S1_RRDY]),
    .txe_ie   (ctrl1_q[C1_TXEIE]),
    .tx_empty (ts_view[TS_TXE]),
    .irq      (irq)
  );

  a_r5_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ctrl1_q == '0 && !rx_full && ctrl2_q == ($past(wv) | C2_RST));

  a_r6_keep_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    we_s1 && !soft_rst |=> s1_q[S1_RTSS] == $past(s1_q[S1_RTSS]) &&
                           s1_q[S1_RXDS] == $past(s1_q[S1_RXDS]));

  a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
    we_tx && !ctrl2_q[C2_TXEN] |=> !tx_strobe);

  a_r12_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl1_q == '0 |-> !irq);

endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_break = 1'b0;
  logic        tx_strobe;
  logic [7:0]  tx_byte;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each registered read result
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd === 1'b1) begin
        @(negedge clk);
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // drivers: called at a falling edge, return at the next falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int widx, input logic [31:0] d);
    bus_addr = 12'(widx * 4); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_start(input int widx, input logic [31:0] e, input string tag);
    bus_addr = 12'(widx * 4); bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic rd(input int widx, input logic [31:0] e, input string tag);
    rd_start(widx, e, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rxb(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd('h25, 32'h3040, "R1 status1");
    rd('h26, 32'h4028, "R1 status2");
    rd('h2D, 32'h0060, "R1 test");
    rd('h20, 32'h0000, "R1 ctrl1");
    rd('h21, 32'h0001, "R1 ctrl2");
    rd('h22, 32'h0700, "R1 ctrl3");
    rd('h24, 32'h0000, "R1 fifo");
    rd('h2A, 32'h0000, "R1 modulator");
    rd('h2B, 32'h0004, "R1 baud count");
    rd('h2C, 32'h0000, "R1 one-ms");
    rd('h00, 32'h4000, "R1 rx data empty");
    rd('h2D, 32'h0060, "R10 empty read has no effect");
    chk("R12 irq at reset", 32'(irq), 32'd0);

    // R2 low 16 bits kept
    wr('h20, 32'h1234_0001); rd('h20, 32'h0001, "R2 ctrl1");
    wr('h22, 32'hFFFF_5A5A); rd('h22, 32'h5A5A, "R2 ctrl3");
    wr('h24, 32'h0001_0081); rd('h24, 32'h0081, "R2 fifo");
    wr('h2A, 32'h0009_1234); rd('h2A, 32'h1234, "R2 modulator");
    wr('h2C, 32'hCAFE_0042); rd('h2C, 32'h0042, "R2 one-ms");
    wr('h21, 32'hFFFF_0007); rd('h21, 32'h0007, "R2 ctrl2");

    // R3 baud count loaded through 0x29
    wr('h29, 32'h0001_00F0); rd('h2B, 32'h00F0, "R3 baud count load");
    rd('h29, 32'h0000, "R3 incremental reads zero");
    wr('h2B, 32'h0000_0055); rd('h2B, 32'h00F0, "R3 write to count ignored");

    // R4 ignored and undecoded
    wr('h23, 32'h0000_FFFF); rd('h23, 32'h0000, "R4 ctrl4");
    wr('h2D, 32'h0000_0000); rd('h2D, 32'h0060, "R4 test write ignored");
    rd('h3F, 32'h0000, "R4 undecoded");
    rd('h10, 32'h0000, "R4 tx word reads zero");

    // R6 write-one-to-clear mask
    wr('h25, 32'h0000_FFFF); rd('h25, 32'h3040, "R6 status1 fixed bits");
    wr('h26, 32'h0000_FFFF); rd('h26, 32'h4028, "R6 status2 fixed bits");

    // R7 accept
    rxb(8'hA5);
    rd('h25, 32'h3240, "R7 status1 rx ready");
    rd('h26, 32'h4029, "R7 status2 data ready");
    rd('h2D, 32'h0040, "R7 test rx not empty");

    // R8 drop while full, R10 consume
    rxb(8'h3C);
    rd('h00, 32'h80A5, "R8 held kept / R10 read");
    rd('h25, 32'h3040, "R10 rx ready cleared");
    rd('h2D, 32'h0060, "R10 empty set");
    rd('h00, 32'h00A5, "R10 empty read no ready bit");

    // R10 read collides with byte arrival
    rxb(8'h11);
    rd_start('h00, 32'h8011, "R10 collision read");
    rx_valid = 1'b1; rx_byte = 8'h22;
    tick();
    bus_rd = 1'b0; rx_valid = 1'b0;
    rd('h00, 32'h0011, "R10 colliding byte dropped");
    rd('h2D, 32'h0060, "R10 collision leaves empty");

    // R9 break
    rxb(8'h33);
    brk();
    rd('h00, 32'h8800, "R9 break overwrites full");
    rx_valid = 1'b1; rx_byte = 8'h66; rx_break = 1'b1;
    tick();
    rx_valid = 1'b0; rx_break = 1'b0;
    rd('h00, 32'h8800, "R9 break wins over byte");
    rxb(8'h44);
    rd_start('h00, 32'h8044, "R9 break with read: old value");
    rx_break = 1'b1;
    tick();
    bus_rd = 1'b0; rx_break = 1'b0;
    rd('h2D, 32'h0040, "R9 break with read keeps full");
    rd('h00, 32'h8800, "R9 break with read stored");

    // R11 transmit
    wr('h10, 32'h0000_01C3);
    chk("R11 strobe high", 32'(tx_strobe), 32'd1);
    chk("R11 byte", 32'(tx_byte), 32'h00C3);
    rd('h25, 32'h1040, "R11 ready low in strobe cycle");
    chk("R11 strobe one cycle", 32'(tx_strobe), 32'd0);
    rd('h25, 32'h3040, "R11 ready back");
    wr('h21, 32'h0000_0003);
    wr('h10, 32'h0000_0099);
    chk("R11 no strobe without enable", 32'(tx_strobe), 32'd0);
    rd('h25, 32'h3040, "R11 ready unchanged without enable");

    // R12 interrupt
    wr('h20, 32'h0000_0200);
    chk("R12 rx enable, empty", 32'(irq), 32'd0);
    rxb(8'h05);
    chk("R12 rx ready irq", 32'(irq), 32'd1);
    rd('h00, 32'h8005, "R12 consume");
    chk("R12 irq cleared by read", 32'(irq), 32'd0);
    wr('h20, 32'h0000_2000);
    chk("R12 tx ready term dropped", 32'(irq), 32'd0);
    wr('h20, 32'h0000_0040);
    chk("R12 tx empty term", 32'(irq), 32'd1);
    wr('h20, 32'h0000_2040);
    chk("R12 both tx terms", 32'(irq), 32'd1);

    // R5 soft reset
    wr('h22, 32'h0000_5A5A);
    wr('h2A, 32'h0000_1234);
    wr('h29, 32'h0000_00F0);
    rxb(8'h77);
    wr('h21, 32'h0000_FFF6);
    chk("R5 irq after soft reset", 32'(irq), 32'd0);
    rd('h20, 32'h0000, "R5 ctrl1");
    rd('h21, 32'hFFF7, "R5 ctrl2 reset bit forced");
    rd('h22, 32'h0700, "R5 ctrl3");
    rd('h2A, 32'h0000, "R5 modulator");
    rd('h2B, 32'h0004, "R5 baud count");
    rd('h24, 32'h0081, "R5 fifo kept");
    rd('h2C, 32'h0042, "R5 one-ms kept");
    rd('h25, 32'h3040, "R5 status1");
    rd('h26, 32'h4028, "R5 status2");
    rd('h2D, 32'h0060, "R5 test");
    rd('h00, 32'h4000, "R5 rx buffer");

    tick();
    tick();
    summary();
    $finish;
  end

endmodule